// File: doc/BRIEF.md
# External data memory access controller

This block serves the data-move requests that an 8-bit microcontroller core issues toward its data memory space. Each request carries a 16-bit address, a flag saying whether the address came from an 8-bit indirect register or from the 16-bit data pointer, a read/write select and a write byte. The controller decides on the spot whether the access lands in the on-chip expanded RAM or on the off-chip bus. It then runs the matching access and returns a single-cycle done pulse together with the read byte.

On-chip accesses use a simple synchronous RAM port that is driven in the same cycle the request is accepted. Off-chip accesses run a fixed six-clock cycle on a multiplexed bus. The low address byte and the data share eight AD lines. An address-latch strobe marks the address phase, separate active-low read and write strobes frame the data phase, and an 8-bit upper port carries the high address byte. When the high byte is not needed, that upper port shows a general-purpose output value instead. A page mode leaves the upper port with its general-purpose value during data-pointer accesses. A 2-bit size field sets how much of the low address space belongs to the on-chip RAM.

The AD lines appear as a separate output, output enable and input, so that a pad ring can build the bidirectional pins. All configuration bits are plain inputs.

Top module: `xmem_ctrl`

## Requirements
- R1: After reset, done is low, ale is low, rd_n and wr_n are high, ad_oe is low, ram_en is low and hi_port equals gpio_hi.
- R2: With cfg_page set, a data-pointer request goes on-chip when its address is below the size limit, and goes external otherwise. The limit is 0x0100 shifted left by cfg_size, so 00=0x0100, 01=0x0200, 10=0x0400 and 11=0x0800.
- R3: With cfg_page set, a data-pointer address of 0x0800 or above goes external for every value of cfg_size.
- R4: An indirect request (req_dptr=0) uses only req_addr[7:0]. It goes on-chip when cfg_page is set or cfg_xsel is low, and then ram_addr equals req_addr[7:0].
- R5: With cfg_page clear, cfg_xsel=1 sends every request external. With cfg_page clear and cfg_xsel=0, a request goes on-chip below the size limit and external at or above it.
- R6: An external access lasts exactly EXT_CYC (6) clocks, counted from the clock after acceptance. ale is high in clock 1 only. In clocks 1 and 2, ad_oe is high and ad_out carries the low address byte.
- R7: In an external read, rd_n is low in clocks 3 to 5 and ad_oe is low in clocks 3 to 6. The rdata output takes the ad_in value present in clock 5, the last clock before rd_n rises.
- R8: In an external write, wr_n is low in clocks 3 to 5, and ad_out carries the write byte with ad_oe high in clocks 3 to 6, one clock past the rise of wr_n.
- R9: During an external data-pointer access with cfg_page clear, hi_port carries req_addr[15:8] in clocks 1 to 6. In every other cycle, including page-mode and indirect accesses, hi_port equals gpio_hi.
- R10: An on-chip access asserts ram_en in the accept cycle, with ram_we equal to req_write and ram_wdata equal to req_wdata. It leaves ale, rd_n and wr_n inactive. done pulses for one cycle, two clocks after acceptance, and a read presents the RAM byte on rdata.
- R11: For an external access, done pulses for one cycle in the clock after clock 6. A req_valid raised while an access is in progress is ignored and changes neither the running cycle nor the count of done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when the controller is idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dptr | input | 1 | 1 = data-pointer address, 0 = indirect 8-bit address |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| rdata | output | 8 | Last read byte |
| done | output | 1 | One-cycle completion pulse |
| cfg_page | input | 1 | Page mode enable |
| cfg_xsel | input | 1 | External select outside page mode |
| cfg_size | input | 2 | On-chip RAM size code |
| gpio_hi | input | 8 | General-purpose value for the upper port |
| ram_en | output | 1 | On-chip RAM enable |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_addr | output | 11 | On-chip RAM address |
| ram_wdata | output | 8 | On-chip RAM write byte |
| ram_rdata | input | 8 | On-chip RAM read byte, valid the clock after ram_en |
| ad_out | output | 8 | AD lines output value |
| ad_oe | output | 1 | AD lines output enable |
| ad_in | input | 8 | AD lines input value |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | External read strobe, active low |
| wr_n | output | 1 | External write strobe, active low |
| hi_port | output | 8 | Upper address / general-purpose port |

## Verification
The on-chip RAM port is due in the accept cycle itself, so the bench checks it after driving the request and before that clock edge. The bench then expects done low one clock later and high, with rdata, the clock after that. For an external access the bench samples the bus once per clock for clocks 1 to 6 counted from the accept edge, and expects done in the seventh. It drives ad_in with the real byte only during clock 5 and with its complement elsewhere, so a read sampled in the wrong clock shows up. All samples are taken on the falling edge, half a period away from the edges that move the registers.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  localparam int XM_ADDR_W  = 16;
  localparam int XM_DATA_W  = 8;
  localparam int XM_SIZE_W  = 2;
  localparam int XM_ERAM_AW = 11;
  localparam int XM_EXT_CYC = 6;
  localparam int XM_BASE    = 256;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ONCHIP = 2'd1,
    ST_EXT    = 2'd2
  } xm_state_e;

endpackage

// File: rtl/xmem_route.sv
module xmem_route
  import xmem_pkg::*;
#(
  parameter int ADDR_W  = XM_ADDR_W,
  parameter int SIZE_W  = XM_SIZE_W,
  parameter int ERAM_AW = XM_ERAM_AW
) (
  input  logic              use_dptr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              page_mode,
  input  logic              ext_sel,
  input  logic [SIZE_W-1:0] size_code,
  output logic              to_onchip,
  output logic              drive_hi,
  output logic [ERAM_AW-1:0] ram_addr
);

  localparam int LIM_W = ADDR_W + 1;

  logic [ADDR_W-1:0] eff_addr;
  logic [LIM_W-1:0]  limit;
  logic              below;

  // indirect accesses carry only a low byte
  always_comb begin
    eff_addr = addr;
    if (!use_dptr) begin
      eff_addr = '0;
      eff_addr[7:0] = addr[7:0];
    end
  end

  assign limit = LIM_W'(XM_BASE) << size_code;
  assign below = ({1'b0, eff_addr} < limit);

  always_comb begin
    if (page_mode) begin
      to_onchip = !use_dptr || below;
    end else begin
      to_onchip = !ext_sel && below;
    end
  end

  assign drive_hi = use_dptr && !page_mode;
  assign ram_addr = eff_addr[ERAM_AW-1:0];

endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int EXT_CYC = XM_EXT_CYC,
  localparam int PH_W   = $clog2(EXT_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_onchip,
  output logic            idle,
  output logic            in_onchip,
  output logic            in_ext,
  output logic [PH_W-1:0] phase,
  output logic            done
);

  xm_state_e       state_q, state_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            done_q, done_d;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (start_onchip) begin
            state_d = ST_ONCHIP;
          end else begin
            state_d = ST_EXT;
            phase_d = PH_W'(1);
          end
        end
      end
      ST_ONCHIP: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      ST_EXT: begin
        if (phase_q == PH_W'(EXT_CYC)) begin
          state_d = ST_IDLE;
          phase_d = '0;
          done_d  = 1'b1;
        end else begin
          phase_d = phase_q + PH_W'(1);
        end
      end
      default: begin
        state_d = ST_IDLE;
        phase_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign in_onchip = (state_q == ST_ONCHIP);
  assign in_ext    = (state_q == ST_EXT);
  assign phase     = phase_q;
  assign done      = done_q;

endmodule

// File: rtl/xmem_bus.sv
module xmem_bus
  import xmem_pkg::*;
#(
  parameter int ADDR_W  = XM_ADDR_W,
  parameter int DATA_W  = XM_DATA_W,
  parameter int EXT_CYC = XM_EXT_CYC,
  localparam int PH_W   = $clog2(EXT_CYC + 1),
  localparam int HI_W   = ADDR_W - DATA_W
) (
  input  logic              in_ext,
  input  logic [PH_W-1:0]   phase,
  input  logic              write,
  input  logic              drive_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [HI_W-1:0]   gpio_hi,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   hi_port,
  output logic              sample_rd
);

  localparam int PH_ALE   = 1;
  localparam int PH_ADDR  = 2;
  localparam int PH_STB0  = PH_ADDR + 1;
  localparam int PH_STB1  = EXT_CYC - 1;

  logic addr_phase;
  logic data_phase;
  logic strobe;

  assign addr_phase = in_ext && (phase <= PH_W'(PH_ADDR));
  assign data_phase = in_ext && (phase >= PH_W'(PH_STB0));
  assign strobe     = data_phase && (phase <= PH_W'(PH_STB1));

  assign ale    = in_ext && (phase == PH_W'(PH_ALE));
  assign rd_n   = !(strobe && !write);
  assign wr_n   = !(strobe && write);
  assign ad_oe  = addr_phase || (data_phase && write);
  assign ad_out = addr_phase ? addr[DATA_W-1:0] : wdata;

  assign hi_port = (in_ext && drive_hi) ? addr[ADDR_W-1:DATA_W] : gpio_hi;

  // last clock before the read strobe rises
  assign sample_rd = in_ext && !write && (phase == PH_W'(PH_STB1));

endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W  = XM_ADDR_W,
  parameter int DATA_W  = XM_DATA_W,
  parameter int SIZE_W  = XM_SIZE_W,
  parameter int ERAM_AW = XM_ERAM_AW,
  parameter int EXT_CYC = XM_EXT_CYC,
  localparam int HI_W   = ADDR_W - DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_dptr,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               done,
  input  logic               cfg_page,
  input  logic               cfg_xsel,
  input  logic [SIZE_W-1:0]  cfg_size,
  input  logic [HI_W-1:0]    gpio_hi,
  output logic               ram_en,
  output logic               ram_we,
  output logic [ERAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0]  ram_wdata,
  input  logic [DATA_W-1:0]  ram_rdata,
  output logic [DATA_W-1:0]  ad_out,
  output logic               ad_oe,
  input  logic [DATA_W-1:0]  ad_in,
  output logic               ale,
  output logic               rd_n,
  output logic               wr_n,
  output logic [HI_W-1:0]    hi_port
);

  localparam int PH_W = $clog2(EXT_CYC + 1);

  logic              route_onchip;
  logic              route_hi;
  logic              idle, in_onchip, in_ext, sample_rd;
  logic [PH_W-1:0]   phase;
  logic              accept;

  logic              q_write, q_write_d;
  logic              q_hi, q_hi_d;
  logic [ADDR_W-1:0] q_addr, q_addr_d;
  logic [DATA_W-1:0] q_wdata, q_wdata_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;

  xmem_route #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W),
    .ERAM_AW(ERAM_AW)
  ) u_route (
    .use_dptr (req_dptr),
    .addr     (req_addr),
    .page_mode(cfg_page),
    .ext_sel  (cfg_xsel),
    .size_code(cfg_size),
    .to_onchip(route_onchip),
    .drive_hi (route_hi),
    .ram_addr (ram_addr)
  );

  xmem_seq #(
    .EXT_CYC(EXT_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (req_valid),
    .start_onchip(route_onchip),
    .idle        (idle),
    .in_onchip   (in_onchip),
    .in_ext      (in_ext),
    .phase       (phase),
    .done        (done)
  );

  assign accept = req_valid && idle;

  // request capture, clock-enabled on accept
  always_comb begin
    q_write_d = q_write;
    q_hi_d    = q_hi;
    q_addr_d  = q_addr;
    q_wdata_d = q_wdata;
    if (accept) begin
      q_write_d = req_write;
      q_hi_d    = route_hi;
      q_addr_d  = req_addr;
      q_wdata_d = req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_write <= 1'b0;
      q_hi    <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
    end else begin
      q_write <= q_write_d;
      q_hi    <= q_hi_d;
      q_addr  <= q_addr_d;
      q_wdata <= q_wdata_d;
    end
  end

  // on-chip port is driven straight from the request in the accept cycle
  assign ram_en    = accept && route_onchip;
  assign ram_we    = ram_en && req_write;
  assign ram_wdata = req_wdata;

  xmem_bus #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .EXT_CYC(EXT_CYC)
  ) u_bus (
    .in_ext   (in_ext),
    .phase    (phase),
    .write    (q_write),
    .drive_hi (q_hi),
    .addr     (q_addr),
    .wdata    (q_wdata),
    .gpio_hi  (gpio_hi),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .hi_port  (hi_port),
    .sample_rd(sample_rd)
  );

  // read data register
  assign rdata_en = sample_rd || (in_onchip && !q_write);

  always_comb begin
    rdata_d = rdata_q;
    if (rdata_en) begin
      rdata_d = sample_rd ? ad_in : ram_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/xmem_ctrl_chk.sv
module xmem_ctrl_chk #(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ale,
  input logic            rd_n,
  input logic            wr_n,
  input logic            ad_oe,
  input logic            done,
  input logic            ram_en,
  input logic [HI_W-1:0] hi_port,
  input logic [HI_W-1:0] gpio_hi
);

  p_ale_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  p_ale_drives_ad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ad_oe);

  p_rd_floats_ad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  p_no_dual_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe);

  p_hi_gpio_onchip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (hi_port == gpio_hi));

  p_onchip_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (rd_n && wr_n && !ale));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind xmem_ctrl xmem_ctrl_chk #(.HI_W(HI_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ale    (ale),
  .rd_n   (rd_n),
  .wr_n   (wr_n),
  .ad_oe  (ad_oe),
  .done   (done),
  .ram_en (ram_en),
  .hi_port(hi_port),
  .gpio_hi(gpio_hi)
);

// File: tb/test_xmem_ctrl.sv
`timescale 1ns/1ps
module test_xmem_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_dptr;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic [7:0]  rdata;
  logic        done;
  logic        cfg_page, cfg_xsel;
  logic [1:0]  cfg_size;
  logic [7:0]  gpio_hi;
  logic        ram_en, ram_we;
  logic [10:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic [7:0]  ad_out, ad_in;
  logic        ad_oe, ale, rd_n, wr_n;
  logic [7:0]  hi_port;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] ram_mem [0:2047];
  logic [7:0] shadow  [0:2047];

  always #2 clk = ~clk;

  xmem_ctrl i_xmem_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_dptr(req_dptr),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rdata(rdata), .done(done),
    .cfg_page(cfg_page), .cfg_xsel(cfg_xsel), .cfg_size(cfg_size),
    .gpio_hi(gpio_hi),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .hi_port(hi_port)
  );

  // synchronous on-chip RAM model
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) ram_mem[ram_addr] <= ram_wdata;
      ram_rdata <= ram_mem[ram_addr];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_onchip(bit page, bit xsel, logic [1:0] sz,
                                    bit dptr, logic [15:0] a);
    int lim;
    int ea;
    lim = 256 * (1 << sz);
    ea  = dptr ? int'(a) : int'(a[7:0]);
    if (page) return !dptr || (ea < lim);
    return !xsel && (ea < lim);
  endfunction

  task automatic run_req(input bit page, input bit xsel, input logic [1:0] sz,
                         input bit dptr, input bit wr, input logic [15:0] a,
                         input logic [7:0] wd, input string tag,
                         input bit inject);
    bit onc;
    logic [7:0] rd_val;
    logic [7:0] hi_exp;
    logic [10:0] ra;
    logic [12:0] act, exp;
    @(negedge clk);
    cfg_page = page; cfg_xsel = xsel; cfg_size = sz;
    req_dptr = dptr; req_write = wr; req_addr = a; req_wdata = wd;
    req_valid = 1'b1;
    gpio_hi = 8'($urandom);
    onc = exp_onchip(page, xsel, sz, dptr, a);
    rd_val = 8'($urandom);
    #0.5;
    chk(ram_en == onc, {tag, " route"}, 32'(ram_en), 32'(onc));
    if (onc) begin
      ra = dptr ? a[10:0] : {3'b000, a[7:0]};
      chk({ram_we, ram_addr, ram_wdata, ale, rd_n, wr_n} ==
          {wr, ra, wd, 1'b0, 1'b1, 1'b1}, "R10 ram port/R4",
          32'({ram_we, ram_addr, ram_wdata, ale, rd_n, wr_n}),
          32'({wr, ra, wd, 1'b0, 1'b1, 1'b1}));
      chk(hi_port == gpio_hi, "R9 onchip hi", 32'(hi_port), 32'(gpio_hi));
      @(negedge clk);
      req_valid = 1'b0;
      chk(done == 1'b0, "R10 done early", 32'(done), 32'd0);
      @(negedge clk);
      chk(done == 1'b1, "R10 done", 32'(done), 32'd1);
      if (wr) shadow[ra] = wd;
      else chk(rdata == shadow[ra], "R10 rdata", 32'(rdata), 32'(shadow[ra]));
      @(negedge clk);
      chk(done == 1'b0, "R10 done pulse", 32'(done), 32'd0);
    end else begin
      hi_exp = (dptr && !page) ? a[15:8] : gpio_hi;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 1; k <= 6; k++) begin
        exp[12]  = (k == 1);
        exp[11]  = !(!wr && k >= 3 && k <= 5);
        exp[10]  = !(wr && k >= 3 && k <= 5);
        exp[9]   = (k <= 2) || wr;
        exp[8]   = 1'b0;
        exp[7:0] = (k <= 2) ? a[7:0] : (wr ? wd : ad_out);
        act = {ale, rd_n, wr_n, ad_oe, 1'b0, ad_out};
        chk(act == exp, $sformatf("%s phase%0d", tag, k), 32'(act), 32'(exp));
        chk(hi_port == hi_exp, "R9 hi_port", 32'(hi_port), 32'(hi_exp));
        chk(done == 1'b0, "R11 done early", 32'(done), 32'd0);
        ad_in = (k == 5) ? rd_val : ~rd_val;
        if (inject && k == 3) req_valid = 1'b1;
        if (inject && k == 4) req_valid = 1'b0;
        @(negedge clk);
      end
      chk(done == 1'b1, "R11 done ext", 32'(done), 32'd1);
      chk({ale, rd_n, wr_n, ad_oe} == 4'b0110, "R6 idle bus",
          32'({ale, rd_n, wr_n, ad_oe}), 32'h6);
      if (!wr) chk(rdata == rd_val, "R7 rdata", 32'(rdata), 32'(rd_val));
      @(negedge clk);
      chk(done == 1'b0, "R11 done pulse", 32'(done), 32'd0);
      if (inject) chk(ale == 1'b0, "R11 no restart", 32'(ale), 32'd0);
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 2048; i++) begin
      ram_mem[i] = 8'h00;
      shadow[i]  = 8'h00;
    end
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_dptr = 0; req_addr = 0; req_wdata = 0;
    cfg_page = 0; cfg_xsel = 0; cfg_size = 0; gpio_hi = 8'hA5; ad_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({done, ale, rd_n, wr_n, ad_oe, ram_en} == 6'b001100, "R1 reset",
        32'({done, ale, rd_n, wr_n, ad_oe, ram_en}), 32'h0C);
    chk(hi_port == 8'hA5, "R1 hi_port", 32'(hi_port), 32'hA5);

    // R2: limit edges for each size code in page mode
    for (int s = 0; s < 4; s++) begin
      run_req(1, 0, 2'(s), 1, 1, 16'(256 * (1 << s) - 1), 8'(s + 8'h30), "R2 below", 0);
      run_req(1, 0, 2'(s), 1, 0, 16'(256 * (1 << s) - 1), 8'h00, "R2 below rd", 0);
      run_req(1, 0, 2'(s), 1, 0, 16'(256 * (1 << s)), 8'h00, "R7 R2 limit", 0);
    end
    // R3: 0x0800 and above stays external
    run_req(1, 0, 2'd3, 1, 1, 16'h0800, 8'h5A, "R8 R3", 0);
    run_req(1, 1, 2'd3, 1, 0, 16'hFFFF, 8'h00, "R7 R3", 0);
    // R4: indirect with page mode, and with xsel low
    run_req(1, 1, 2'd0, 0, 1, 16'hAB77, 8'hC3, "R4 page", 0);
    run_req(0, 0, 2'd0, 0, 0, 16'h1277, 8'h00, "R4 xsel0", 0);
    // R5: xsel high sends both sources external; R9 high byte driven
    run_req(0, 1, 2'd3, 1, 1, 16'h0012, 8'h99, "R8 R5", 0);
    run_req(0, 1, 2'd2, 0, 0, 16'h3456, 8'h00, "R7 R5", 0);
    run_req(0, 0, 2'd1, 1, 0, 16'h0200, 8'h00, "R7 R5 limit", 0);
    // R11: request raised mid-cycle is ignored
    run_req(0, 1, 2'd0, 1, 0, 16'h4321, 8'h00, "R11 R6", 1);

    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      bit wr;
      a  = ($urandom % 2) ? 16'($urandom % 16'h0900) : 16'($urandom);
      wr = 1'($urandom);
      run_req(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), wr, a,
              8'($urandom), wr ? "R8 rand" : "R7 rand", 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule